// File: doc/BRIEF.md
# Disk Controller Host Port Interface

This block sits between an 8-bit processor I/O bus and a slower back-end controller that imitates a classic hard-disk controller. It claims the sixteen I/O ports 0xC0 to 0xCF. A read of the status port 0xCF is served entirely in hardware from a shadow status register. Every other access in the window stalls the processor with a wait signal and is posted to the back-end as a request. The request holds the port number, the direction and the write data until the back-end reports completion.

The back-end finishes a request in one of two ways. It can transfer the data at once, or it can clear the READY bit in the status register, release the bus and finish the work later. In the second case the host polls the status port until READY is set again. The back-end writes the status register through a three-wire serial path with clock, data and latch. The bits shift in MSB first, and the register the bus sees changes only when the latch line rises.

All host and back-end inputs are synchronous to `clk`. The host keeps its strobes asserted for as long as the wait is high, and drops them for at least one cycle between accesses.

Top module: `hdc_host_port`

## Requirements
- R1: The external data-buffer enable `buf_en` is high in the same cycle exactly when `io_req` and `rd` are high and `addr[7:4]` is 4'hC.
- R2: A read of port 0xCF drives the latched status byte on `rdata` in the same cycle, never raises `bus_wait` and never raises `req_valid`.
- R3: A read of 0xC0 to 0xCE, or a write to any port in the window, raises `bus_wait` in its first cycle. `req_valid` rises one cycle later with `req_port` = `addr[3:0]`, `req_write` = 1 for a write, and `req_wdata` = `wdata`. These stay stable until `be_done`.
- R4: `bus_wait` stays high until the back-end pulses `be_done`, and is low from the cycle after the pulse. For a read, `rdata` then carries the `be_rdata` value presented with the pulse. `req_valid` drops in the same cycle.
- R5: A write to the status port 0xCF is not served locally: it is posted to the back-end with `req_port` = 4'hF and `req_write` = 1.
- R6: On each rising edge of `st_sck`, `st_sdi` is shifted in MSB first. The value a status read returns changes only on a rising edge of `st_latch`, which copies the last eight shifted bits.
- R7: After reset, `bus_wait` and `req_valid` are low and a status read returns 0x00.
- R8: An access that arrives while an earlier request is still pending (its host access was abandoned) is held with `bus_wait`. It is posted one cycle after the earlier request's `be_done`.
- R9: When the status register is latched in the same cycle as a status read, that cycle returns the old value and the next cycle returns the new one. This lets the back-end clear READY on a deferred command and set it again later while the host polls.
- R10: An access outside the window, or with `io_req` low, raises neither `bus_wait` nor `buf_en` and posts no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Host I/O request strobe |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe |
| addr | input | 8 | Host I/O port address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data returned to host |
| buf_en | output | 1 | External data-buffer enable for selected reads |
| bus_wait | output | 1 | Host bus wait request |
| req_valid | output | 1 | Request pending to back-end |
| req_port | output | 4 | Port number of pending request |
| req_write | output | 1 | Pending request is a write |
| req_wdata | output | 8 | Write data of pending request |
| be_rdata | input | 8 | Read data from back-end, valid with be_done |
| be_done | input | 1 | One-cycle completion pulse from back-end |
| st_sck | input | 1 | Status serial shift clock |
| st_sdi | input | 1 | Status serial data, MSB first |
| st_latch | input | 1 | Status latch strobe, copies on rising edge |

## Verification
Two functions can act in the same cycle: the host polling the status port and the back-end latching a new status byte. The bench holds a read of 0xCF steady, shifts a new byte in, and then raises `st_latch` during the read. It expects the old byte on `rdata` in that cycle and the new byte in the next one. A second overlap, a back-end completion arriving while a new access is already waiting, is judged by the one-cycle gap on `req_valid` and by the new port number that follows.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
    localparam int DW = 8;
    localparam int PW = 4;

    typedef struct packed {
        logic          pending;
        logic          mine;
        logic          served;
        logic [PW-1:0] port;
        logic          write;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } ctrl_t;

    typedef struct packed {
        logic          sck;
        logic          latch;
        logic [DW-1:0] shreg;
        logic [DW-1:0] status;
    } stat_t;
endpackage

// File: rtl/hdc_decode.sv
module hdc_decode #(
    parameter int AW       = 8,
    parameter int PW       = 4,
    parameter logic [AW-PW-1:0] WIN_BASE = 4'hC,
    parameter logic [PW-1:0]    STAT_IDX = 4'hF
) (
    input  logic          io_req,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic          sel,
    output logic          stat_rd,
    output logic          be_acc,
    output logic [PW-1:0] port
);
    logic is_stat;

    always_comb begin
        sel     = io_req && (addr[AW-1:PW] == WIN_BASE);
        port    = addr[PW-1:0];
        is_stat = (port == STAT_IDX);
        stat_rd = sel && rd && is_stat;
        be_acc  = sel && (wr || (rd && !is_stat));
    end
endmodule

// File: rtl/hdc_status_shifter.sv
module hdc_status_shifter
    import hdc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_sck,
    input  logic          st_sdi,
    input  logic          st_latch,
    output logic [DW-1:0] status
);
    stat_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sck   = st_sck;
        st_d.latch = st_latch;
        if (st_sck && !st_q.sck) begin
            st_d.shreg = {st_q.shreg[DW-2:0], st_sdi};
        end
        if (st_latch && !st_q.latch) begin
            st_d.status = st_q.shreg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.status;
endmodule

// File: rtl/hdc_req_ctrl.sv
module hdc_req_ctrl
    import hdc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          be_acc,
    input  logic [PW-1:0] port,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] be_rdata,
    input  logic          be_done,
    output logic          wait_o,
    output logic          req_valid,
    output logic [PW-1:0] req_port,
    output logic          req_write,
    output logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rdata
);
    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (c_q.pending && be_done) begin
            c_d.pending = 1'b0;
            c_d.mine    = 1'b0;
            if (c_q.mine && be_acc) begin
                c_d.served = 1'b1;
                if (!c_q.write) begin
                    c_d.rdata = be_rdata;
                end
            end
        end else if (be_acc && !c_q.served && !c_q.pending) begin
            c_d.pending = 1'b1;
            c_d.mine    = 1'b1;
            c_d.port    = port;
            c_d.write   = wr;
            c_d.wdata   = wdata;
        end
        if (!be_acc) begin
            c_d.served = 1'b0;
            c_d.mine   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign wait_o    = be_acc && !c_q.served;
    assign req_valid = c_q.pending;
    assign req_port  = c_q.port;
    assign req_write = c_q.write;
    assign req_wdata = c_q.wdata;
    assign rdata     = c_q.rdata;
endmodule

// File: rtl/hdc_host_port.sv
module hdc_host_port
    import hdc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_req,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          buf_en,
    output logic          bus_wait,
    output logic          req_valid,
    output logic [PW-1:0] req_port,
    output logic          req_write,
    output logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] be_rdata,
    input  logic          be_done,
    input  logic          st_sck,
    input  logic          st_sdi,
    input  logic          st_latch
);
    logic          sel, stat_rd, be_acc;
    logic [PW-1:0] port;
    logic [DW-1:0] status_q, be_rd_q;

    hdc_decode #(.AW(AW), .PW(PW)) u_dec (
        .io_req (io_req),
        .rd     (rd),
        .wr     (wr),
        .addr   (addr),
        .sel    (sel),
        .stat_rd(stat_rd),
        .be_acc (be_acc),
        .port   (port)
    );

    hdc_status_shifter u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_sck  (st_sck),
        .st_sdi  (st_sdi),
        .st_latch(st_latch),
        .status  (status_q)
    );

    hdc_req_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .be_acc   (be_acc),
        .port     (port),
        .wr       (wr),
        .wdata    (wdata),
        .be_rdata (be_rdata),
        .be_done  (be_done),
        .wait_o   (bus_wait),
        .req_valid(req_valid),
        .req_port (req_port),
        .req_write(req_write),
        .req_wdata(req_wdata),
        .rdata    (be_rd_q)
    );

    assign buf_en = sel && rd;
    assign rdata  = stat_rd ? status_q : be_rd_q;
endmodule

// File: rtl/hdc_host_port_chk.sv
module hdc_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_req,
    input logic       rd,
    input logic       wr,
    input logic [7:0] addr,
    input logic [7:0] rdata,
    input logic       buf_en,
    input logic       bus_wait,
    input logic       req_valid,
    input logic [3:0] req_port,
    input logic       req_write,
    input logic [7:0] req_wdata,
    input logic       be_done,
    input logic       st_latch,
    input logic [7:0] status_q
);
    logic in_win, acc;
    assign in_win = io_req && (addr[7:4] == 4'hC);
    assign acc    = in_win && (wr || (rd && addr[3:0] != 4'hF));

    // R2: status read never stalls
    p_stat_no_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && rd && !wr && addr[3:0] == 4'hF) |-> (!bus_wait && rdata == status_q));

    // R3: first cycle of a back-end access stalls
    p_wait_at_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !$past(acc)) |-> bus_wait);

    // R3: request fields stay put until completion
    p_req_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !be_done) |=> (req_valid && $stable(req_port)
                                     && $stable(req_write) && $stable(req_wdata)));

    // R6: status only changes after a latch rise
    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_latch && !$past(st_latch)) |=> $stable(status_q));

    // R10: outside the window nothing reacts
    p_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> (!bus_wait && !buf_en));

    // R1: buffer enable only on selected reads
    p_buf_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en |-> (in_win && rd));
endmodule

bind hdc_host_port hdc_host_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_req   (io_req),
    .rd       (rd),
    .wr       (wr),
    .addr     (addr),
    .rdata    (rdata),
    .buf_en   (buf_en),
    .bus_wait (bus_wait),
    .req_valid(req_valid),
    .req_port (req_port),
    .req_write(req_write),
    .req_wdata(req_wdata),
    .be_done  (be_done),
    .st_latch (st_latch),
    .status_q (status_q)
);

// File: tb/sim_hdc_host_port.sv
`timescale 1ns/1ps
module sim_hdc_host_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_req = 0, rd = 0, wr = 0;
    logic [7:0] addr = 0, wdata = 0, be_rdata = 0;
    logic       be_done = 0, st_sck = 0, st_sdi = 0, st_latch = 0;
    logic [7:0] rdata, req_wdata;
    logic       buf_en, bus_wait, req_valid, req_write;
    logic [3:0] req_port;
    int checks = 0, errors = 0;
    bit done_all = 0;

    always #2.5 clk = ~clk;

    hdc_host_port u0 (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask
    task automatic settle(); #0.5; endtask

    task automatic host(input logic r, input logic w, input logic [7:0] a, input logic [7:0] d);
        io_req = r | w; rd = r; wr = w; addr = a; wdata = d;
    endtask

    task automatic idle(); host(0, 0, 8'h00, 8'h00); endtask

    task automatic load_status(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            cyc(); st_sdi = v[i]; st_sck = 0;
            cyc(); st_sck = 1;
        end
        cyc(); st_sck = 0;
    endtask

    task automatic pulse_latch();
        cyc(); st_latch = 1;
        cyc(); st_latch = 0;
    endtask

    task automatic finish_req(input logic [7:0] d);
        cyc(); be_done = 1; be_rdata = d;
        cyc(); be_done = 0; settle();
    endtask

    task automatic t_reset();
        cyc(); host(1, 0, 8'hCF, 0); settle();
        chk("R7 status after reset", rdata, 8'h00);
        chk("R7 wait after reset", {7'd0, bus_wait}, 8'd0);
        chk("R7 req after reset", {7'd0, req_valid}, 8'd0);
        cyc(); idle();
    endtask

    task automatic t_status_load();
        cyc(); host(1, 0, 8'hCF, 0);
        load_status(8'hA5); settle();
        chk("R6 no change before latch", rdata, 8'h00);
        pulse_latch(); settle();
        chk("R6 latched value MSB first", rdata, 8'hA5);
        chk("R2 no wait on status read", {7'd0, bus_wait}, 8'd0);
        chk("R1 buf_en on status read", {7'd0, buf_en}, 8'd1);
        cyc(); settle();
        chk("R2 no request from status read", {7'd0, req_valid}, 8'd0);
        idle();
    endtask

    task automatic t_outside();
        cyc(); host(1, 0, 8'hB3, 0); settle();
        chk("R10 no wait outside", {7'd0, bus_wait}, 8'd0);
        chk("R10 no buf_en outside", {7'd0, buf_en}, 8'd0);
        cyc(); settle();
        chk("R10 no request outside", {7'd0, req_valid}, 8'd0);
        cyc(); host(0, 0, 8'hC3, 0); rd = 1; settle();
        chk("R1 buf_en needs io_req", {7'd0, buf_en}, 8'd0);
        cyc(); host(0, 1, 8'hD3, 8'h11); settle();
        chk("R10 write outside no wait", {7'd0, bus_wait}, 8'd0);
        cyc(); settle();
        chk("R10 write outside no request", {7'd0, req_valid}, 8'd0);
        idle();
    endtask

    task automatic t_read();
        cyc(); host(1, 0, 8'hC4, 0); settle();
        chk("R3 wait in first cycle", {7'd0, bus_wait}, 8'd1);
        chk("R1 buf_en on data read", {7'd0, buf_en}, 8'd1);
        cyc(); settle();
        chk("R3 req_valid next cycle", {7'd0, req_valid}, 8'd1);
        chk("R3 req_port", {4'd0, req_port}, 8'h04);
        chk("R3 req_write read", {7'd0, req_write}, 8'd0);
        cyc(); cyc(); settle();
        chk("R4 wait held while pending", {7'd0, bus_wait}, 8'd1);
        finish_req(8'h5A);
        chk("R4 wait released", {7'd0, bus_wait}, 8'd0);
        chk("R4 read data", rdata, 8'h5A);
        chk("R4 req dropped", {7'd0, req_valid}, 8'd0);
        cyc(); settle();
        chk("R4 no re-post of served access", {7'd0, req_valid}, 8'd0);
        idle();
    endtask

    task automatic t_write_status_port();
        cyc(); host(0, 1, 8'hCF, 8'h77); settle();
        chk("R5 wait on status write", {7'd0, bus_wait}, 8'd1);
        cyc(); settle();
        chk("R5 req port F", {4'd0, req_port}, 8'h0F);
        chk("R5 req write", {7'd0, req_write}, 8'd1);
        chk("R3 req wdata", req_wdata, 8'h77);
        finish_req(8'h00);
        chk("R5 released", {7'd0, bus_wait}, 8'd0);
        cyc(); idle();
    endtask

    task automatic t_overlap();
        cyc(); host(1, 0, 8'hC2, 0);
        cyc(); settle();
        chk("R8 first request posted", {4'd0, req_port}, 8'h02);
        idle();
        cyc(); host(0, 1, 8'hC3, 8'h3E);
        cyc(); cyc(); settle();
        chk("R8 new access waits", {7'd0, bus_wait}, 8'd1);
        chk("R8 old request kept", {4'd0, req_port}, 8'h02);
        finish_req(8'h00);
        chk("R8 gap after done", {7'd0, req_valid}, 8'd0);
        chk("R8 still waiting", {7'd0, bus_wait}, 8'd1);
        cyc(); settle();
        chk("R8 new request posted", {7'd0, req_valid}, 8'd1);
        chk("R8 new port", {4'd0, req_port}, 8'h03);
        chk("R8 new wdata", req_wdata, 8'h3E);
        finish_req(8'h00);
        chk("R8 released", {7'd0, bus_wait}, 8'd0);
        cyc(); idle();
    endtask

    task automatic t_deferred_poll();
        cyc(); host(0, 1, 8'hC7, 8'h20);
        load_status(8'h00); pulse_latch();
        finish_req(8'h00);
        cyc(); host(1, 0, 8'hCF, 0); settle();
        chk("R9 READY cleared while busy", rdata, 8'h00);
        load_status(8'h40); settle();
        chk("R9 poll still busy", rdata, 8'h00);
        cyc(); st_latch = 1; settle();
        chk("R9 same-cycle latch returns old", rdata, 8'h00);
        cyc(); st_latch = 0; settle();
        chk("R9 next cycle returns new", rdata, 8'h40);
        idle();
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        t_reset();
        t_status_load();
        t_outside();
        t_read();
        t_write_status_port();
        t_overlap();
        t_deferred_poll();
        done_all = 1;
    end

    initial begin
        fork
            wait (done_all);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule